// File: doc/BRIEF.md
# Self-Checking Ripple Adder with Per-Cell Fault Flags

This block is an N-bit ripple-carry adder in which every one-bit adder cell checks its own work and raises its own error flag. The check rests on a property of a one-bit addition. When the cell's three inputs (operand bit A, operand bit B, incoming carry) all hold the same value, the correct sum and carry-out are equal. In every other case they are opposite. Each cell computes an active-low "inputs agree" indication. It then compares sum against carry-out with an XNOR, and compares that result against the agreement indication with a second XNOR. A 1 from the second XNOR marks the cell as faulty.

Each cell judges itself against the carry it actually receives. A corrupted carry leaving a lower cell therefore raises only that cell's flag, and every higher cell stays clear. Sum and carry-out are built from separate product terms with no shared XOR stage, so one internal upset cannot corrupt both outputs the same way. For test and fault studies, each cell has three XOR masks: one on its sum net, one on its carry-out net and one on its agreement net. All masks are zero in normal use. The block is purely combinational.

Top module: `sca_adder`

## Requirements
- R1: With all fault masks zero, {cout, sum} equals a + b + cin as an (N+1)-bit unsigned value.
- R2: With all fault masks zero, every bit of cell_err is 0 for any operands and carry-in.
- R3: Setting inj_sum[i] alone flips sum[i] and raises cell_err[i] only; every other flag stays 0.
- R4: Setting inj_cout[i] alone raises cell_err[i] only. The cells above i receive the flipped carry, but their flags stay 0.
- R5: Setting inj_tst[i] alone raises cell_err[i] only, and leaves sum and cout at their fault-free values.
- R6: With a=1, b=0, cin=1 and inj_sum bit 0 set, sum bit 0 reads 1 and cell_err bit 0 reads 1.
- R7: Two masks set together in the same cell (any two of sum, carry-out and agreement nets) leave that cell's flag at 0. Such double faults escape detection.
- R8: Faults in different cells are judged independently. With at most one mask set per cell, cell_err equals the OR of the three mask vectors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand |
| b | input | N | Second operand |
| cin | input | 1 | Carry into cell 0 |
| inj_sum | input | N | Per-cell XOR mask on the sum net |
| inj_cout | input | N | Per-cell XOR mask on the carry-out net |
| inj_tst | input | N | Per-cell XOR mask on the active-low agreement net |
| sum | output | N | Sum bits after any injected flips |
| cout | output | 1 | Carry out of cell N-1 after any injected flip |
| cell_err | output | N | Per-cell error flag, 1 marks a fault in that cell |

## Verification
The bench builds two instances: one at the default N=16 and one at N=2. The narrow instance makes every combination of operands and carry-in reachable, each paired with every single fault, so each cell sees all eight three-input patterns with both a carry-in of 0 and a carry-in of 1. The wide instance runs table vectors and random operands with one fault per sweep. Its long carry chain lets a flipped carry pass through many clean cells, which must keep their flags clear.

// File: rtl/sca_pkg.sv
package sca_pkg;

    // Inputs of one adder cell
    typedef struct packed {
        logic opa;
        logic opb;
        logic cy;
    } cell_in_t;

    // Per-cell fault masks
    typedef struct packed {
        logic sum;
        logic cout;
        logic tst;
    } cell_flt_t;

    // Sum built as a standalone parity term
    function automatic logic sum_fn(cell_in_t x);
        return x.opa ^ x.opb ^ x.cy;
    endfunction

    // Carry built as a majority of products, no XOR shared with the sum
    function automatic logic carry_fn(cell_in_t x);
        return (x.opa & x.opb) | (x.opa & x.cy) | (x.opb & x.cy);
    endfunction

endpackage

// File: rtl/sca_eq_tester.sv
module sca_eq_tester
    import sca_pkg::*;
(
    input  cell_in_t in_i,
    output logic     tst_n_o
);
    logic all_one;
    logic all_zero;

    always_comb begin
        all_one  = in_i.opa & in_i.opb & in_i.cy;
        all_zero = ~in_i.opa & ~in_i.opb & ~in_i.cy;
        tst_n_o  = ~(all_one | all_zero);
    end
endmodule

// File: rtl/sca_cell_check.sv
module sca_cell_check (
    input  logic sum_i,
    input  logic cout_i,
    input  logic tst_n_i,
    output logic err_o
);
    logic mid;

    always_comb begin
        mid   = ~(sum_i ^ cout_i);
        err_o = ~(mid ^ tst_n_i);
    end
endmodule

// File: rtl/sca_cell.sv
module sca_cell
    import sca_pkg::*;
(
    input  cell_in_t  in_i,
    input  cell_flt_t flt_i,
    output logic      sum_o,
    output logic      cout_o,
    output logic      err_o
);
    logic sum_raw;
    logic cout_raw;
    logic tst_raw;
    logic tst_n;

    sca_eq_tester u_tst (
        .in_i    (in_i),
        .tst_n_o (tst_raw)
    );

    always_comb begin
        sum_raw  = sum_fn(in_i);
        cout_raw = carry_fn(in_i);
        sum_o    = sum_raw ^ flt_i.sum;
        cout_o   = cout_raw ^ flt_i.cout;
        tst_n    = tst_raw ^ flt_i.tst;
    end

    sca_cell_check u_chk (
        .sum_i   (sum_o),
        .cout_i  (cout_o),
        .tst_n_i (tst_n),
        .err_o   (err_o)
    );

    always_comb begin
        // R2
        clean_cell_chk: assert ((flt_i != '0) || (err_o == 1'b0));
        // R3
        single_flag_chk: assert (($countones(flt_i) != 1) || (err_o == 1'b1));
        // R7
        double_escape_chk: assert (($countones(flt_i) != 2) || (err_o == 1'b0));
    end
endmodule

// File: rtl/sca_adder.sv
module sca_adder
    import sca_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    input  logic [N-1:0] inj_sum,
    input  logic [N-1:0] inj_cout,
    input  logic [N-1:0] inj_tst,
    output logic [N-1:0] sum,
    output logic         cout,
    output logic [N-1:0] cell_err
);
    localparam int CW = N + 1;

    logic [N:0] cy;

    assign cy[0] = cin;

    for (genvar i = 0; i < N; i++) begin : g_cell
        cell_in_t  cin_s;
        cell_flt_t flt_s;

        assign cin_s = '{opa: a[i], opb: b[i], cy: cy[i]};
        assign flt_s = '{sum: inj_sum[i], cout: inj_cout[i], tst: inj_tst[i]};

        sca_cell u_cell (
            .in_i   (cin_s),
            .flt_i  (flt_s),
            .sum_o  (sum[i]),
            .cout_o (cy[i+1]),
            .err_o  (cell_err[i])
        );
    end

    assign cout = cy[N];

    always_comb begin
        // R1
        clean_sum_chk: assert (((inj_sum | inj_cout | inj_tst) != '0) ||
            ({cout, sum} == ({1'b0, a} + {1'b0, b} + CW'(cin))));
        // R8
        flag_local_chk: assert ((cell_err & ~(inj_sum | inj_cout | inj_tst)) == '0);
    end
endmodule

// File: tb/sim_sca_adder.sv
module sim_sca_adder;
    localparam int CLK_T = 10;
    localparam int W    = 16;
    localparam int WS   = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_T/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    // wide instance
    logic [W-1:0] a, b, fs, fc, fe, s, e;
    logic ci, co;

    sca_adder #(.N(W)) u0 (
        .a(a), .b(b), .cin(ci), .inj_sum(fs), .inj_cout(fc), .inj_tst(fe),
        .sum(s), .cout(co), .cell_err(e)
    );

    // narrow instance
    logic [WS-1:0] na, nb, nfs, nfc, nfe, ns, ne;
    logic nci, nco;

    sca_adder #(.N(WS)) u1 (
        .a(na), .b(nb), .cin(nci), .inj_sum(nfs), .inj_cout(nfc), .inj_tst(nfe),
        .sum(ns), .cout(nco), .cell_err(ne)
    );

    typedef struct packed {
        logic [W-1:0] va;
        logic [W-1:0] vb;
        logic         vci;
        logic [W-1:0] vfs;
        logic [W-1:0] vfc;
        logic [W-1:0] vfe;
        logic [W-1:0] verr;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{16'h0000, 16'h0000, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0000}, // R2 idle
        '{16'h0001, 16'h0000, 1'b1, 16'h0001, 16'h0000, 16'h0000, 16'h0001}, // R6
        '{16'hFFFF, 16'h0001, 1'b0, 16'h0000, 16'h0001, 16'h0000, 16'h0001}, // R4 long chain
        '{16'h1234, 16'h4321, 1'b0, 16'h0000, 16'h0000, 16'h8000, 16'h8000}, // R5
        '{16'hAAAA, 16'h5555, 1'b1, 16'h0010, 16'h0010, 16'h0000, 16'h0000}, // R7
        '{16'h0F0F, 16'h3C3C, 1'b0, 16'h0101, 16'h1000, 16'h0020, 16'h1121}, // R8
        '{16'hFFFF, 16'hFFFF, 1'b1, 16'h0000, 16'h4000, 16'h0000, 16'h4000}, // R4
        '{16'h7FFF, 16'h0001, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0000}  // R1
    };

    task automatic chk(input bit ok, input string tag, input logic [W:0] act, input logic [W:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_w(input logic [W-1:0] ia, input logic [W-1:0] ib, input logic ici,
                           input logic [W-1:0] ifs, input logic [W-1:0] ifc, input logic [W-1:0] ife);
        @(negedge clk);
        a = ia; b = ib; ci = ici; fs = ifs; fc = ifc; fe = ife;
        #1;
    endtask

    // R1 with masks on sum only: expected = true sum xor sum mask
    function automatic logic [W:0] exp_w(input logic [W-1:0] ia, input logic [W-1:0] ib,
                                         input logic ici, input logic [W-1:0] ifs);
        return ({1'b0, ia} + {1'b0, ib} + {{W{1'b0}}, ici}) ^ {1'b0, ifs};
    endfunction

    initial begin
        #(CLK_T * 150000);
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        a = '0; b = '0; ci = 1'b0; fs = '0; fc = '0; fe = '0;
        na = '0; nb = '0; nci = 1'b0; nfs = '0; nfc = '0; nfe = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // idle state: all zero in, no flags, zero sum (R2, R1)
        @(negedge clk); #1;
        chk(e == '0, "R2 idle flags", {1'b0, e}, '0);
        chk({co, s} == '0, "R1 idle sum", {co, s}, '0);

        // table walk
        foreach (TBL[k]) begin
            drive_w(TBL[k].va, TBL[k].vb, TBL[k].vci, TBL[k].vfs, TBL[k].vfc, TBL[k].vfe);
            chk(e == TBL[k].verr, "R8 table flags", {1'b0, e}, {1'b0, TBL[k].verr});
            if (TBL[k].vfc == '0)
                chk({co, s} == exp_w(TBL[k].va, TBL[k].vb, TBL[k].vci, TBL[k].vfs),
                    "R1 table sum", {co, s}, exp_w(TBL[k].va, TBL[k].vb, TBL[k].vci, TBL[k].vfs));
        end

        // R6 sum bit 0 itself
        drive_w(16'h0001, 16'h0000, 1'b1, 16'h0001, 16'h0000, 16'h0000);
        chk(s[0] == 1'b1 && e[0] == 1'b1, "R6 flipped sum", {{(W-1){1'b0}}, s[0], e[0]}, 2'b11);

        // narrow instance: every operand pair and carry-in, each single fault
        for (int v = 0; v < 32; v++) begin
            for (int f = 0; f < 7; f++) begin
                logic [WS-1:0] ma, mb;
                logic [WS:0] tru;
                ma = v[3:2]; mb = v[1:0];
                tru = {1'b0, ma} + {1'b0, mb} + {2'b00, v[4]};
                @(negedge clk);
                na = ma; nb = mb; nci = v[4];
                nfs = '0; nfc = '0; nfe = '0;
                case (f)
                    1: nfs = 2'b01;
                    2: nfs = 2'b10;
                    3: nfc = 2'b01;
                    4: nfc = 2'b10;
                    5: nfe = 2'b01;
                    6: nfe = 2'b10;
                    default: ;
                endcase
                #1;
                if (f == 0) begin
                    chk(ne == '0, "R2 narrow flags", {{(W-1){1'b0}}, ne}, '0);
                    chk({nco, ns} == tru, "R1 narrow sum", {{(W-2){1'b0}}, nco, ns}, {{(W-2){1'b0}}, tru});
                end else if (f <= 2) begin
                    chk(ne == nfs, "R3 narrow flag", {{(W-1){1'b0}}, ne}, {{(W-1){1'b0}}, nfs});
                    chk({nco, ns} == (tru ^ {1'b0, nfs}), "R3 narrow sum",
                        {{(W-2){1'b0}}, nco, ns}, {{(W-2){1'b0}}, tru ^ {1'b0, nfs}});
                end else if (f <= 4) begin
                    chk(ne == nfc, "R4 narrow flag", {{(W-1){1'b0}}, ne}, {{(W-1){1'b0}}, nfc});
                end else begin
                    chk(ne == nfe, "R5 narrow flag", {{(W-1){1'b0}}, ne}, {{(W-1){1'b0}}, nfe});
                    chk({nco, ns} == tru, "R5 narrow sum", {{(W-2){1'b0}}, nco, ns}, {{(W-2){1'b0}}, tru});
                end
            end
        end

        // narrow instance: double faults in one cell escape (R7)
        for (int c = 0; c < WS; c++) begin
            for (int p = 0; p < 3; p++) begin
                @(negedge clk);
                na = 2'b01; nb = 2'b10; nci = 1'b1;
                nfs = '0; nfc = '0; nfe = '0;
                if (p != 0) nfs[c] = 1'b1;
                if (p != 1) nfc[c] = 1'b1;
                if (p != 2) nfe[c] = 1'b1;
                #1;
                chk(ne[c] == 1'b0, "R7 double fault escape", {{(W){1'b0}}, ne[c]}, '0);
            end
        end

        // wide instance: per-cell uniform patterns, each single fault in each cell
        for (int pat = 0; pat < 8; pat++) begin
            for (int c = 0; c < W; c++) begin
                logic [W-1:0] oa, ob, m;
                oa = {W{pat[2]}}; ob = {W{pat[1]}}; m = '0; m[c] = 1'b1;
                drive_w(oa, ob, pat[0], m, '0, '0);
                chk(e == m, "R3 wide sum fault", {1'b0, e}, {1'b0, m});
                drive_w(oa, ob, pat[0], '0, m, '0);
                chk(e == m, "R4 wide carry fault", {1'b0, e}, {1'b0, m});
                drive_w(oa, ob, pat[0], '0, '0, m);
                chk(e == m, "R5 wide tester fault", {1'b0, e}, {1'b0, m});
                chk({co, s} == exp_w(oa, ob, pat[0], '0), "R5 wide sum intact",
                    {co, s}, exp_w(oa, ob, pat[0], '0));
            end
        end

        // wide instance: random operands, clean and one random fault per cell group
        for (int r = 0; r < 300; r++) begin
            logic [W-1:0] ra, rb, mfs, mfc, mfe;
            logic rc;
            ra = W'($urandom); rb = W'($urandom); rc = 1'($urandom);
            drive_w(ra, rb, rc, '0, '0, '0);
            chk(e == '0, "R2 random clean flags", {1'b0, e}, '0);
            chk({co, s} == exp_w(ra, rb, rc, '0), "R1 random sum", {co, s}, exp_w(ra, rb, rc, '0));
            mfs = '0; mfc = '0; mfe = '0;
            for (int c = 0; c < W; c++) begin
                int k;
                k = int'($urandom_range(0, 3));
                if (k == 1) mfs[c] = 1'b1;
                if (k == 2) mfc[c] = 1'b1;
                if (k == 3) mfe[c] = 1'b1;
            end
            drive_w(ra, rb, rc, mfs, mfc, mfe);
            chk(e == (mfs | mfc | mfe), "R8 random multi-cell flags", {1'b0, e}, {1'b0, mfs | mfc | mfe});
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule